// File: doc/BRIEF.md
# UART Flag and Control Register Block

This block is the software-facing side of a UART. It keeps the receive and transmit status flags, the error and idle-line flags, the 9th data bit in both directions, the break request and the flags of a LIN-style serial link. It combines all enabled flags into one interrupt line. Software reaches it over a byte-wide register bus with separate read and write strobes and a 3-bit address. A separate serial engine drives single-cycle event pulses into the block. That engine takes transmit bytes from it over a valid/ready stream.

The error flags and the idle flag clear only through an ordered pair of accesses. The first is a status read. The second is a data-register read that comes straight after it, with no other register access in between. The transmission-complete flag clears the same way, except that the second access is a data-register write. One tracker bit remembers that a status read was the last access. The next access of any kind consumes that bit.

The transmit stream is `tx_valid`/`tx_ready`. `tx_valid` is high whenever the holding byte is full, which is the same as the transmit-empty flag being low. A byte moves on a clock edge where both are high. While `tx_ready` is low, `tx_byte` and `tx_bit8` stay stable until software writes the data register again. A write overwrites a byte that has not yet been accepted.

Top module: `uart_flag_regs`

## Requirements
- R1: After reset, `status_flags` is 0xC0 (bit 7 transmit-empty and bit 6 transmission-complete set, all others clear). Every enable, the break request, the LIN flags, `irq` and `tx_valid` are 0.
- R2: An `ev_rx_done` pulse sets status bit 5 (receive-not-empty) one cycle later. It also loads `ev_rx_byte` into the data register (address 1) and `ev_rx_bit8` into bit 7 of config register A (address 2).
- R3: Receive-not-empty clears on any read of address 1. It also clears on a write to the status register (address 0) with bit 5 at 0. A status write with bit 5 at 1 leaves it set.
- R4: Status bits 0 to 4 (parity, framing, noise, overrun, idle) are set by their event pulses. They clear only when a read of address 1 directly follows a read of address 0. A data read with no status read before it leaves them set.
- R5: Any access to another address between the status read and the data access cancels the sequence, so the following data read leaves bits 0 to 4 set.
- R6: `ev_tx_drained` sets status bit 6 (transmission-complete). It clears only when a write to address 1 directly follows a read of address 0.
- R7: A write to address 1 clears status bit 7 and loads `tx_byte`. It also loads `tx_bit8` from bit 6 of config register A. `tx_valid` equals the inverse of bit 7. The byte holds stable while `tx_ready` is low, and a handshake sets bit 7 again. A data write in the same cycle as a handshake keeps bit 7 clear, so the new byte stays pending.
- R8: Writing 1 to bit 0 of config register B (address 3) raises `send_break`. Writing 0 there has no effect. `ev_break_sent` clears it.
- R9: LIN events set three flags: break at address 4 bit 4, header at address 5 bit 0, and sync at address 5 bit 1. They also appear on `lin_flags` as {sync, header, break}. Writing 0 to a flag's bit clears it, and writing 1 leaves it unchanged.
- R10: `irq` is high when any of these pairs has both members set:
  - parity flag and address 2 bit 0
  - bit 7 and address 3 bit 7
  - bit 6 and address 3 bit 6
  - bit 5 or bit 3, with address 3 bit 5
  - bit 4 and address 3 bit 4
  - LIN break and address 4 bit 5
  - LIN header and address 5 bit 6
- R11: When a setting event and a clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| ev_rx_done | input | 1 | Receive complete pulse |
| ev_rx_byte | input | 8 | Received low byte |
| ev_rx_bit8 | input | 1 | Received 9th bit |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_noise_err | input | 1 | Noise pulse |
| ev_overrun | input | 1 | Overrun pulse |
| ev_idle_line | input | 1 | Idle line pulse |
| ev_tx_drained | input | 1 | Transmit shifter empty pulse |
| ev_break_sent | input | 1 | Break stop bit reached |
| ev_lin_break | input | 1 | LIN break detected |
| ev_lin_header | input | 1 | LIN header detected |
| ev_lin_sync | input | 1 | LIN sync field seen |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Engine accepts transmit byte |
| tx_byte | output | 8 | Transmit low byte |
| tx_bit8 | output | 1 | Transmit 9th bit |
| status_flags | output | 8 | Status register value |
| lin_flags | output | 3 | {sync, header, break} |
| send_break | output | 1 | Break request |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is combinational, so `bus_rdata` is due in the same cycle as the read strobe. Every flag, enable and transmit output changes at the first rising edge after its event pulse, bus write or handshake. `irq` follows in that same cycle because it is decoded directly from the registers. The driver changes inputs just after a rising edge. The monitor compares read data at the falling edge inside the strobe cycle. Direct output checks also sample at a falling edge, after the edge that applied the stimulus, so each check falls exactly one register stage after its cause.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NFLAG  = 8;
  localparam int unsigned NLIN   = 3;
  localparam int unsigned NIRQ   = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT   = 3'd0,
    A_DATA   = 3'd1,
    A_CFGA   = 3'd2,
    A_CFGB   = 3'd3,
    A_LINBRK = 3'd4,
    A_LINHDR = 3'd5
  } reg_addr_e;

  // status bit positions
  localparam int unsigned ST_PE   = 0;
  localparam int unsigned ST_FE   = 1;
  localparam int unsigned ST_NE   = 2;
  localparam int unsigned ST_OVR  = 3;
  localparam int unsigned ST_IDLE = 4;
  localparam int unsigned ST_RXNE = 5;
  localparam int unsigned ST_TC   = 6;
  localparam int unsigned ST_TXE  = 7;
  localparam int unsigned NERR    = 5;

  localparam logic [NFLAG-1:0] STAT_RST = 8'hC0;
endpackage

// File: rtl/uart_flag_cell.sv
`timescale 1ns/1ps
module uart_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R11: a set pulse always leaves the flag high
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/uart_seq_tracker.sv
`timescale 1ns/1ps
module uart_seq_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic wr_i,
  input  logic is_stat_i,
  input  logic is_data_i,
  output logic clr_err_o,
  output logic clr_tc_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed_q <= 1'b0;
    else if (rd_i && is_stat_i)  armed_q <= 1'b1;
    else if (rd_i || wr_i)       armed_q <= 1'b0;
  end

  assign clr_err_o = armed_q && rd_i && is_data_i;
  assign clr_tc_o  = armed_q && wr_i && is_data_i;

  // R5: an access that is not a status access leaves nothing armed
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_i || wr_i) && !is_stat_i) |=> (!clr_err_o && !clr_tc_o));
endmodule

// File: rtl/uart_irq_combine.sv
`timescale 1ns/1ps
module uart_irq_combine #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = flags_i[i] & en_i[i];
  end

  assign irq_o = |hit;

  // R10: with every enable low the line stays quiet
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/uart_flag_regs.sv
`timescale 1ns/1ps
module uart_flag_regs
  import uart_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 ev_rx_done,
  input  logic [DATA_W-1:0]    ev_rx_byte,
  input  logic                 ev_rx_bit8,
  input  logic                 ev_parity_err,
  input  logic                 ev_frame_err,
  input  logic                 ev_noise_err,
  input  logic                 ev_overrun,
  input  logic                 ev_idle_line,
  input  logic                 ev_tx_drained,
  input  logic                 ev_break_sent,
  input  logic                 ev_lin_break,
  input  logic                 ev_lin_header,
  input  logic                 ev_lin_sync,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [DATA_W-1:0]    tx_byte,
  output logic                 tx_bit8,
  output logic [NFLAG-1:0]     status_flags,
  output logic [NLIN-1:0]      lin_flags,
  output logic                 send_break,
  output logic                 irq
);
  // access decode
  logic is_stat, is_data, is_cfga, is_cfgb, is_linbrk, is_linhdr;
  assign is_stat   = (bus_addr == A_STAT);
  assign is_data   = (bus_addr == A_DATA);
  assign is_cfga   = (bus_addr == A_CFGA);
  assign is_cfgb   = (bus_addr == A_CFGB);
  assign is_linbrk = (bus_addr == A_LINBRK);
  assign is_linhdr = (bus_addr == A_LINHDR);

  logic data_rd, data_wr, tx_hs;
  assign data_rd = bus_rd && is_data;
  assign data_wr = bus_wr && is_data;

  logic clr_err, clr_tc;
  uart_seq_tracker u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (bus_rd),
    .wr_i      (bus_wr),
    .is_stat_i (is_stat),
    .is_data_i (is_data),
    .clr_err_o (clr_err),
    .clr_tc_o  (clr_tc)
  );

  // status flags
  logic [NFLAG-1:0] st_set, st_clr, stat_q;

  always_comb begin
    st_set          = '0;
    st_set[ST_PE]   = ev_parity_err;
    st_set[ST_FE]   = ev_frame_err;
    st_set[ST_NE]   = ev_noise_err;
    st_set[ST_OVR]  = ev_overrun;
    st_set[ST_IDLE] = ev_idle_line;
    st_set[ST_RXNE] = ev_rx_done;
    st_set[ST_TC]   = ev_tx_drained;
    st_set[ST_TXE]  = tx_hs && !data_wr;

    st_clr              = '0;
    st_clr[NERR-1:0]    = {NERR{clr_err}};
    st_clr[ST_RXNE]     = data_rd || (bus_wr && is_stat && !bus_wdata[ST_RXNE]);
    st_clr[ST_TC]       = clr_tc;
    st_clr[ST_TXE]      = data_wr;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_stat
    uart_flag_cell #(.RST_VAL(STAT_RST[i])) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set[i]),
      .clr_i (st_clr[i]),
      .q_o   (stat_q[i])
    );
  end

  // LIN flags: index 0 break, 1 header, 2 sync
  logic [NLIN-1:0] lin_set, lin_clr, lin_q;
  assign lin_set = {ev_lin_sync, ev_lin_header, ev_lin_break};
  assign lin_clr = {bus_wr && is_linhdr && !bus_wdata[1],
                    bus_wr && is_linhdr && !bus_wdata[0],
                    bus_wr && is_linbrk && !bus_wdata[4]};

  for (genvar j = 0; j < NLIN; j++) begin : g_lin
    uart_flag_cell #(.RST_VAL(1'b0)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (lin_set[j]),
      .clr_i (lin_clr[j]),
      .q_o   (lin_q[j])
    );
  end

  // break request: software sets, engine clears
  logic brk_q;
  uart_flag_cell #(.RST_VAL(1'b0)) u_brk (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (bus_wr && is_cfgb && bus_wdata[0]),
    .clr_i (ev_break_sent),
    .q_o   (brk_q)
  );

  // configuration and data holding registers
  logic              t8_q, pe_ie_q, txe_ie_q, tc_ie_q, rxne_ie_q, idle_ie_q;
  logic              lbk_ie_q, lhd_ie_q, rx_b8_q, tx_b8_q;
  logic [DATA_W-1:0] rx_byte_q, tx_byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t8_q      <= 1'b0;
      pe_ie_q   <= 1'b0;
      txe_ie_q  <= 1'b0;
      tc_ie_q   <= 1'b0;
      rxne_ie_q <= 1'b0;
      idle_ie_q <= 1'b0;
      lbk_ie_q  <= 1'b0;
      lhd_ie_q  <= 1'b0;
      rx_b8_q   <= 1'b0;
      tx_b8_q   <= 1'b0;
      rx_byte_q <= '0;
      tx_byte_q <= '0;
    end else begin
      if (bus_wr && is_cfga) begin
        t8_q    <= bus_wdata[6];
        pe_ie_q <= bus_wdata[0];
      end
      if (bus_wr && is_cfgb) begin
        txe_ie_q  <= bus_wdata[7];
        tc_ie_q   <= bus_wdata[6];
        rxne_ie_q <= bus_wdata[5];
        idle_ie_q <= bus_wdata[4];
      end
      if (bus_wr && is_linbrk) lbk_ie_q <= bus_wdata[5];
      if (bus_wr && is_linhdr) lhd_ie_q <= bus_wdata[6];
      if (ev_rx_done) begin
        rx_byte_q <= ev_rx_byte;
        rx_b8_q   <= ev_rx_bit8;
      end
      if (data_wr) begin
        tx_byte_q <= bus_wdata;
        tx_b8_q   <= t8_q;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:   bus_rdata = stat_q;
      A_DATA:   bus_rdata = rx_byte_q;
      A_CFGA:   bus_rdata = {rx_b8_q, t8_q, 5'b0, pe_ie_q};
      A_CFGB:   bus_rdata = {txe_ie_q, tc_ie_q, rxne_ie_q, idle_ie_q, 3'b0, brk_q};
      A_LINBRK: bus_rdata = {2'b0, lbk_ie_q, lin_q[0], 4'b0};
      A_LINHDR: bus_rdata = {1'b0, lhd_ie_q, 4'b0, lin_q[2], lin_q[1]};
      default:  bus_rdata = '0;
    endcase
  end

  // interrupt sources
  logic [NIRQ-1:0] irq_flags, irq_en;
  assign irq_flags = {stat_q[ST_PE], stat_q[ST_TXE], stat_q[ST_TC], stat_q[ST_RXNE],
                      stat_q[ST_OVR], stat_q[ST_IDLE], lin_q[0], lin_q[1]};
  assign irq_en    = {pe_ie_q, txe_ie_q, tc_ie_q, rxne_ie_q,
                      rxne_ie_q, idle_ie_q, lbk_ie_q, lhd_ie_q};

  uart_irq_combine #(.N(NIRQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (irq_flags),
    .en_i    (irq_en),
    .irq_o   (irq)
  );

  assign tx_valid     = !stat_q[ST_TXE];
  assign tx_hs        = tx_valid && tx_ready;
  assign tx_byte      = tx_byte_q;
  assign tx_bit8      = tx_b8_q;
  assign status_flags = stat_q;
  assign lin_flags    = lin_q;
  assign send_break   = brk_q;

  // R4: an error flag falls only after a data read
  p_err_clear_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[ST_PE]) |-> $past(bus_rd && (bus_addr == A_DATA)));

  // R7: transmit-empty falls only after a data write
  p_txe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[ST_TXE]) |-> $past(bus_wr && (bus_addr == A_DATA)));

  // R7: stalled stream holds its payload
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !data_wr) |=> (tx_valid && $stable(tx_byte) && $stable(tx_bit8)));

  // R8: break request drops only on the engine's pulse
  p_brk_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(send_break) |-> $past(ev_break_sent));
endmodule

// File: tb/tb_uart_flag_regs.sv
`timescale 1ns/1ps
module tb_uart_flag_regs;
  import uart_regs_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       ev_rx_done = 0, ev_rx_bit8 = 0;
  logic [7:0] ev_rx_byte = '0;
  logic       ev_parity_err = 0, ev_frame_err = 0, ev_noise_err = 0, ev_overrun = 0;
  logic       ev_idle_line = 0, ev_tx_drained = 0, ev_break_sent = 0;
  logic       ev_lin_break = 0, ev_lin_header = 0, ev_lin_sync = 0;
  logic       tx_valid, tx_ready = 0, tx_bit8, send_break, irq;
  logic [7:0] tx_byte, status_flags;
  logic [2:0] lin_flags;

  uart_flag_regs dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb[$];

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: compares read data inside each read strobe cycle
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (sb.size() == 0) chk(8'hxx, 8'h00, "scoreboard empty");
      else begin
        exp_t it;
        it = sb.pop_front();
        chk(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    step();
    sb.push_back('{exp, tag});
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b, input logic b8);
    step();
    ev_rx_done = 1; ev_rx_byte = b; ev_rx_bit8 = b8;
    step();
    ev_rx_done = 0;
  endtask

  // mask order: lin_sync lin_hdr lin_brk brk_sent drained idle ovr noise frame parity
  task automatic pulse(input logic [9:0] m);
    step();
    {ev_lin_sync, ev_lin_header, ev_lin_break, ev_break_sent, ev_tx_drained,
     ev_idle_line, ev_overrun, ev_noise_err, ev_frame_err, ev_parity_err} = m;
    step();
    {ev_lin_sync, ev_lin_header, ev_lin_break, ev_break_sent, ev_tx_drained,
     ev_idle_line, ev_overrun, ev_noise_err, ev_frame_err, ev_parity_err} = '0;
  endtask

  task automatic look(input logic [7:0] got_dummy);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(status_flags, 8'hC0, "R1 status after reset");
    chk({4'b0, irq, tx_valid, send_break, 1'b0}, 8'h00, "R1 irq/tx_valid/break");
    chk({5'b0, lin_flags}, 8'h00, "R1 lin flags");
    rd(A_CFGB, 8'h00, "R1 cfgb reset");

    // R2 receive
    rx(8'hA5, 1'b1);
    @(negedge clk); chk(status_flags, 8'hE0, "R2 rxne set");
    rd(A_CFGA, 8'h80, "R2 ninth bit");
    rd(A_DATA, 8'hA5, "R2 data byte");
    @(negedge clk); chk(status_flags, 8'hC0, "R3 rxne cleared by data read");

    // R3 status write
    rx(8'h3C, 1'b0);
    wr(A_STAT, 8'hFF);
    @(negedge clk); chk(status_flags, 8'hE0, "R3 status write bit5=1 keeps rxne");
    wr(A_STAT, 8'h00);
    @(negedge clk); chk(status_flags, 8'hC0, "R3 status write bit5=0 clears rxne");

    // R4 error clearing sequence
    pulse(10'h01F);
    @(negedge clk); chk(status_flags, 8'hDF, "R4 error flags set");
    rd(A_DATA, 8'h3C, "R4 lone data read");
    @(negedge clk); chk(status_flags, 8'hDF, "R4 lone data read keeps errors");
    rd(A_STAT, 8'hDF, "R4 status read");
    rd(A_DATA, 8'h3C, "R4 data read after status");
    @(negedge clk); chk(status_flags, 8'hC0, "R4 errors cleared");

    // R5 interrupted sequence
    pulse(10'h010);
    rd(A_STAT, 8'hD0, "R5 status read");
    rd(A_CFGB, 8'h00, "R5 other access");
    rd(A_DATA, 8'h3C, "R5 data read");
    @(negedge clk); chk(status_flags, 8'hD0, "R5 idle kept after broken sequence");
    rd(A_STAT, 8'hD0, "R5 status read again");
    rd(A_DATA, 8'h3C, "R5 data read again");
    @(negedge clk); chk(status_flags, 8'hC0, "R5 idle cleared");

    // R7 transmit stream, R6 completion flag
    wr(A_CFGA, 8'h40);
    wr(A_DATA, 8'h5A);
    @(negedge clk);
    chk(status_flags, 8'h40, "R7 txe cleared, R6 tc kept without status read");
    chk({tx_valid, tx_bit8, 6'b0}, 8'hC0, "R7 valid and ninth bit");
    chk(tx_byte, 8'h5A, "R7 tx byte");
    repeat (3) step();
    @(negedge clk);
    chk({tx_valid, 7'b0}, 8'h80, "R7 valid held under back-pressure");
    chk(tx_byte, 8'h5A, "R7 byte held under back-pressure");
    step(); tx_ready = 1'b1; step(); tx_ready = 1'b0;
    @(negedge clk);
    chk(status_flags, 8'hC0, "R7 handshake sets txe");
    chk({tx_valid, 7'b0}, 8'h00, "R7 valid dropped");
    rd(A_STAT, 8'hC0, "R6 status read");
    wr(A_DATA, 8'h11);
    @(negedge clk); chk(status_flags, 8'h00, "R6 tc cleared by sequence");
    chk(tx_byte, 8'h11, "R7 second byte");
    step(); tx_ready = 1'b1; step(); tx_ready = 1'b0;
    @(negedge clk); chk(status_flags, 8'h80, "R7 second handshake");
    pulse(10'h020);
    @(negedge clk); chk(status_flags, 8'hC0, "R6 tc set by drained pulse");

    // R8 break request
    wr(A_CFGB, 8'h01);
    @(negedge clk); chk({7'b0, send_break}, 8'h01, "R8 break set");
    wr(A_CFGB, 8'h00);
    @(negedge clk); chk({7'b0, send_break}, 8'h01, "R8 zero write ignored");
    pulse(10'h040);
    @(negedge clk); chk({7'b0, send_break}, 8'h00, "R8 cleared by engine");

    // R9 LIN flags
    pulse(10'h380);
    @(negedge clk); chk({5'b0, lin_flags}, 8'h07, "R9 lin flags set");
    rd(A_LINBRK, 8'h10, "R9 lin break bit");
    rd(A_LINHDR, 8'h03, "R9 header and sync bits");
    wr(A_LINHDR, 8'h02);
    rd(A_LINHDR, 8'h02, "R9 header cleared, sync kept");
    wr(A_LINBRK, 8'h00);
    rd(A_LINBRK, 8'h00, "R9 break cleared");
    wr(A_LINHDR, 8'h00);
    @(negedge clk); chk({5'b0, lin_flags}, 8'h00, "R9 all lin flags clear");

    // R10 interrupt
    @(negedge clk); chk({7'b0, irq}, 8'h00, "R10 irq quiet");
    wr(A_CFGB, 8'h80);
    @(negedge clk); chk({7'b0, irq}, 8'h01, "R10 txe enabled");
    wr(A_CFGB, 8'h10);
    @(negedge clk); chk({7'b0, irq}, 8'h00, "R10 idle enable, no idle");
    pulse(10'h010);
    @(negedge clk); chk({7'b0, irq}, 8'h01, "R10 idle irq");
    rd(A_STAT, 8'hD0, "R10 status read");
    rd(A_DATA, 8'h3C, "R10 data read");
    @(negedge clk); chk({7'b0, irq}, 8'h00, "R10 idle irq cleared");
    wr(A_CFGB, 8'h00);
    wr(A_LINBRK, 8'h20);
    pulse(10'h080);
    @(negedge clk); chk({7'b0, irq}, 8'h01, "R10 lin break irq");
    rd(A_LINBRK, 8'h30, "R10 lin break readback");
    wr(A_LINBRK, 8'h20);
    @(negedge clk); chk({7'b0, irq}, 8'h00, "R10 lin break irq cleared");
    wr(A_CFGA, 8'h01);
    pulse(10'h001);
    @(negedge clk); chk({7'b0, irq}, 8'h01, "R10 parity irq");
    wr(A_CFGA, 8'h00);
    @(negedge clk); chk({7'b0, irq}, 8'h00, "R10 parity masked");
    chk(status_flags, 8'hC1, "R10 parity flag remains");
    rd(A_STAT, 8'hC1, "R10 status read parity");
    rd(A_DATA, 8'h3C, "R10 data read parity");

    // R11 set wins over clear
    step();
    sb.push_back('{8'h3C, "R11 data read during receive"});
    bus_addr = A_DATA; bus_rd = 1'b1;
    ev_rx_done = 1'b1; ev_rx_byte = 8'h77; ev_rx_bit8 = 1'b0;
    step();
    bus_rd = 1'b0; ev_rx_done = 1'b0;
    @(negedge clk); chk(status_flags, 8'hE0, "R11 rxne stays set");
    rd(A_DATA, 8'h77, "R11 new byte");
    rd(A_STAT, 8'hC0, "R11 status read");
    step();
    sb.push_back('{8'h77, "R11 data read with idle"});
    bus_addr = A_DATA; bus_rd = 1'b1; ev_idle_line = 1'b1;
    step();
    bus_rd = 1'b0; ev_idle_line = 1'b0;
    @(negedge clk); chk(status_flags, 8'hD0, "R11 idle stays set");

    repeat (3) step();
    chk(8'(sb.size()), 8'h00, "scoreboard drained");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule